// File: doc/BRIEF.md
# PCI INTx to ISA IRQ steering router

This block takes four active-low PCI interrupt lines and steers each one onto one line of a 16-line, active-high ISA IRQ bus. Every PCI line owns a 4-bit steering code. The codes are packed two to a byte in a pair of mapping registers. A small sensitivity register chooses, for each line, how the interrupt is delivered. In level mode the IRQ tracks the PCI line. In edge mode the IRQ carries a single one-clock pulse for each new assertion.

Firmware programs the router through a plain register port. That port has an index, write data, a write strobe and read data. The read data is combinational and follows the index. When several PCI lines are steered to the same IRQ, their contributions are merged with a logical OR. Codes with no IRQ assigned, and codes that are reserved, leave the line unconnected.

Top module: `intx_irq_steer`

## Requirements
- R1: While reset is asserted, and after its release until software writes, all steering codes and sensitivity bits are zero. Every irq output is low whatever the intx_n inputs do, and indices 0x42, 0x43 and 0x44 read 0x00.
- R2: Index 0x42 holds the code of INT1 in bits 3:0 and the code of INT2 in bits 7:4. Index 0x43 holds the code of INT3 in bits 3:0 and the code of INT4 in bits 7:4. A write with reg_wr high takes effect at that clock edge. Reading either index returns the stored byte.
- R3: Index 0x44 bit n (n = 0..3) selects the mode of line INT(n+1): 1 is edge, 0 is level. Bits 7:4 are not stored and read as zero.
- R4: Steering code to IRQ number: 1→9, 2→3, 3→10, 4→4, 5→5, 6→7, 7→6, 9→11, 11→12, 13→14, 15→15. An asserted line drives irq[n] of its IRQ number n.
- R5: Code 0 and the reserved codes 8, 10, 12 and 14 drive no IRQ. irq[0], irq[1], irq[2], irq[8] and irq[13] are never driven high.
- R6: In level mode the target IRQ goes high on the first clock edge that samples intx_n low. It stays high while the line stays low, and goes low on the first edge that samples the line high.
- R7: In edge mode a high-to-low change of intx_n makes the target IRQ high for exactly one clock, starting after the first edge that samples the line low. No further pulse follows until the line is released and asserted again.
- R8: Lines steered to the same IRQ are ORed. The IRQ stays high while any of them is active.
- R9: Writes to any index other than 0x42, 0x43 and 0x44 change no stored state. Reads of such indices return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| intx_n | input | 4 | Active-low PCI interrupt lines, bit 0 = INT1 |
| reg_idx | input | 8 | Register index for reads and writes |
| reg_wdata | input | 8 | Write data |
| reg_wr | input | 1 | Write strobe, one write per clock while high |
| reg_rdata | output | 8 | Read data for reg_idx (combinational) |
| irq | output | 16 | Active-high ISA IRQ lines, bit n = IRQ n |

## Verification
The bench builds the router with its default parameters: four lines, 4-bit codes, byte-wide registers at 0x42/0x43/0x44, and a 16-line IRQ bus. This exposes all sixteen code values, both nibble halves of both mapping registers, and every IRQ number the table can reach. It also lets two lines collide on one IRQ while a third line runs in edge mode next to them. The timing checks sample one and two clocks after each change of intx_n. This pins down the single register stage and the exact width of the edge pulse.

// File: rtl/steer_pkg.sv
package steer_pkg;

  typedef enum logic {
    TRIG_LEVEL = 1'b0,
    TRIG_EDGE  = 1'b1
  } trig_mode_e;

  typedef struct packed {
    logic       hit;
    logic [3:0] num;
  } irq_sel_t;

  // Non-linear steering table; reserved and zero codes give no hit.
  function automatic irq_sel_t code_to_irq(input logic [3:0] code);
    irq_sel_t s;
    s.hit = 1'b1;
    unique case (code)
      4'd1:    s.num = 4'd9;
      4'd2:    s.num = 4'd3;
      4'd3:    s.num = 4'd10;
      4'd4:    s.num = 4'd4;
      4'd5:    s.num = 4'd5;
      4'd6:    s.num = 4'd7;
      4'd7:    s.num = 4'd6;
      4'd9:    s.num = 4'd11;
      4'd11:   s.num = 4'd12;
      4'd13:   s.num = 4'd14;
      4'd15:   s.num = 4'd15;
      default: begin
        s.hit = 1'b0;
        s.num = 4'd0;
      end
    endcase
    return s;
  endfunction

endpackage

// File: rtl/steer_regs.sv
module steer_regs #(
  parameter int LINES    = 4,
  parameter int CODE_W   = 4,
  parameter int IDX_W    = 8,
  parameter int DATA_W   = 8,
  parameter int MAP_BASE = 'h42,
  parameter int SENS_IDX = 'h44
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [IDX_W-1:0]             reg_idx,
  input  logic [DATA_W-1:0]            reg_wdata,
  input  logic                         reg_wr,
  output logic [DATA_W-1:0]            reg_rdata,
  output logic [LINES-1:0][CODE_W-1:0] codes,
  output logic [LINES-1:0]             sens
);
  localparam int PER_REG = DATA_W / CODE_W;
  localparam int NUM_MAP = (LINES + PER_REG - 1) / PER_REG;
  localparam logic [IDX_W-1:0] SENS_A = IDX_W'(SENS_IDX);

  logic [NUM_MAP-1:0][DATA_W-1:0] map_q;
  logic [LINES-1:0]               sens_q;

  for (genvar r = 0; r < NUM_MAP; r++) begin : g_map
    localparam logic [IDX_W-1:0] MY_A = IDX_W'(MAP_BASE + r);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         map_q[r] <= '0;
      else if (reg_wr && reg_idx == MY_A) map_q[r] <= reg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           sens_q <= '0;
    else if (reg_wr && reg_idx == SENS_A) sens_q <= reg_wdata[LINES-1:0];
  end

  for (genvar l = 0; l < LINES; l++) begin : g_code
    assign codes[l] = map_q[l / PER_REG][(l % PER_REG)*CODE_W +: CODE_W];
  end
  assign sens = sens_q;

  always_comb begin
    reg_rdata = '0;
    for (int r = 0; r < NUM_MAP; r++) begin
      if (reg_idx == IDX_W'(MAP_BASE + r)) reg_rdata = map_q[r];
    end
    if (reg_idx == SENS_A) reg_rdata = DATA_W'(sens_q);
  end

endmodule

// File: rtl/steer_trig.sv
module steer_trig #(
  parameter int LINES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] intx_n,
  input  logic [LINES-1:0] sens,
  output logic [LINES-1:0] act
);
  import steer_pkg::*;

  logic [LINES-1:0] asrt_q;
  logic [LINES-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      asrt_q <= '0;
      prev_q <= '0;
    end else begin
      asrt_q <= ~intx_n;
      prev_q <= asrt_q;
    end
  end

  for (genvar l = 0; l < LINES; l++) begin : g_line
    trig_mode_e mode;
    assign mode   = trig_mode_e'(sens[l]);
    assign act[l] = (mode == TRIG_EDGE) ? (asrt_q[l] & ~prev_q[l]) : asrt_q[l];
  end

endmodule

// File: rtl/steer_decode.sv
module steer_decode #(
  parameter int CODE_W = 4,
  parameter int IRQ_W  = 16
) (
  input  logic [CODE_W-1:0] code,
  output logic [IRQ_W-1:0]  hot
);
  import steer_pkg::*;

  irq_sel_t sel;

  always_comb begin
    sel = code_to_irq(4'(code));
    hot = '0;
    if (sel.hit) hot[sel.num] = 1'b1;
  end

endmodule

// File: rtl/intx_irq_steer.sv
module intx_irq_steer #(
  parameter int LINES    = 4,
  parameter int CODE_W   = 4,
  parameter int IDX_W    = 8,
  parameter int DATA_W   = 8,
  parameter int IRQ_W    = 16,
  parameter int MAP_BASE = 'h42,
  parameter int SENS_IDX = 'h44
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINES-1:0]  intx_n,
  input  logic [IDX_W-1:0]  reg_idx,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_wr,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [IRQ_W-1:0]  irq
);
  logic [LINES-1:0][CODE_W-1:0] codes;
  logic [LINES-1:0]             sens;
  logic [LINES-1:0]             act;
  logic [LINES-1:0][IRQ_W-1:0]  hot;

  steer_regs #(
    .LINES(LINES), .CODE_W(CODE_W), .IDX_W(IDX_W), .DATA_W(DATA_W),
    .MAP_BASE(MAP_BASE), .SENS_IDX(SENS_IDX)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
    .reg_wr(reg_wr), .reg_rdata(reg_rdata), .codes(codes), .sens(sens)
  );

  steer_trig #(.LINES(LINES)) u_trig (
    .clk(clk), .rst_n(rst_n), .intx_n(intx_n), .sens(sens), .act(act)
  );

  for (genvar l = 0; l < LINES; l++) begin : g_dec
    steer_decode #(.CODE_W(CODE_W), .IRQ_W(IRQ_W)) u_dec (
      .code(codes[l]), .hot(hot[l])
    );
  end

  always_comb begin
    irq = '0;
    for (int l = 0; l < LINES; l++) irq |= hot[l] & {IRQ_W{act[l]}};
  end

endmodule

// File: rtl/steer_chk.sv
module steer_chk #(
  parameter int LINES    = 4,
  parameter int CODE_W   = 4,
  parameter int IDX_W    = 8,
  parameter int DATA_W   = 8,
  parameter int IRQ_W    = 16,
  parameter int MAP_BASE = 'h42,
  parameter int SENS_IDX = 'h44
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [LINES-1:0]             intx_n,
  input logic [IDX_W-1:0]             reg_idx,
  input logic                         reg_wr,
  input logic [DATA_W-1:0]            reg_rdata,
  input logic [IRQ_W-1:0]             irq,
  input logic [LINES-1:0][CODE_W-1:0] codes,
  input logic [LINES-1:0]             sens,
  input logic [LINES-1:0]             act
);
  localparam logic [IRQ_W-1:0] NEVER = IRQ_W'(16'h2107);
  localparam int NUM_MAP = (LINES * CODE_W + DATA_W - 1) / DATA_W;

  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  logic own_idx;
  assign own_idx = (reg_idx == IDX_W'(SENS_IDX)) ||
                   (reg_idx >= IDX_W'(MAP_BASE) && reg_idx < IDX_W'(MAP_BASE + NUM_MAP));

  assert_foreign_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !own_idx) |=> ($stable(codes) && $stable(sens)));

  assert_sens_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_idx == IDX_W'(SENS_IDX)) |-> (reg_rdata[DATA_W-1:LINES] == '0));

  assert_no_unused_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq & NEVER) == '0);

  for (genvar l = 0; l < LINES; l++) begin : g_line
    assert_level_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && !sens[l]) |-> (act[l] == $past(!intx_n[l])));

    assert_edge_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (sens[l] && act[l]) |=> !(sens[l] && act[l]));
  end

endmodule

bind intx_irq_steer steer_chk #(
  .LINES(LINES), .CODE_W(CODE_W), .IDX_W(IDX_W), .DATA_W(DATA_W),
  .IRQ_W(IRQ_W), .MAP_BASE(MAP_BASE), .SENS_IDX(SENS_IDX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .intx_n(intx_n), .reg_idx(reg_idx),
  .reg_wr(reg_wr), .reg_rdata(reg_rdata), .irq(irq), .codes(codes),
  .sens(sens), .act(act)
);

// File: tb/test_intx_irq_steer.sv
module test_intx_irq_steer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  intx_n = 4'h0;
  logic [7:0]  reg_idx = 8'h00;
  logic [7:0]  reg_wdata = 8'h00;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_rdata;
  logic [15:0] irq;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  intx_irq_steer i_intx_irq_steer (
    .clk(clk), .rst_n(rst_n), .intx_n(intx_n), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_wr(reg_wr), .reg_rdata(reg_rdata), .irq(irq)
  );

  // expected IRQ number per code, 31 = none
  localparam logic [4:0] EXP_IRQ [16] = '{
    5'd31, 5'd9, 5'd3, 5'd10, 5'd4, 5'd5, 5'd7, 5'd6,
    5'd31, 5'd11, 5'd31, 5'd12, 5'd31, 5'd14, 5'd31, 5'd15
  };

  function automatic logic [15:0] bit_of(input int n);
    return 16'(1) << n;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] idx, input logic [7:0] val);
    @(negedge clk);
    reg_idx = idx; reg_wdata = val; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input string req, input logic [7:0] idx, input logic [7:0] exp);
    reg_idx = idx;
    #1;
    chk(req, 32'(reg_rdata), 32'(exp));
  endtask

  task automatic drive(input logic [3:0] v);
    intx_n = v;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1: reset with all lines asserted
    repeat (3) @(negedge clk);
    chk("R1 irq in reset", 32'(irq), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 irq after reset", 32'(irq), 32'h0);
    rd("R1 map0", 8'h42, 8'h00);
    rd("R1 map1", 8'h43, 8'h00);
    rd("R1 sens", 8'h44, 8'h00);
    drive(4'hF);

    // table walk on INT1, level mode: R2 readback, R4/R5 decode, R6 release
    for (int c = 0; c < 16; c++) begin
      wr(8'h42, 8'(c));
      rd("R2 readback", 8'h42, 8'(c));
      drive(4'b1110);
      if (EXP_IRQ[c] == 5'd31) chk("R5 no irq", 32'(irq), 32'h0);
      else chk("R4 decode", 32'(irq), 32'(bit_of(int'(EXP_IRQ[c]))));
      drive(4'b1111);
      chk("R6 release", 32'(irq), 32'h0);
    end

    // R2 nibble positions
    wr(8'h42, 8'h21);
    wr(8'h43, 8'h43);
    rd("R2 map1 readback", 8'h43, 8'h43);
    drive(4'b1101);
    chk("R2 INT2 high nibble", 32'(irq), 32'(bit_of(3)));
    drive(4'b1011);
    chk("R2 INT3 low nibble", 32'(irq), 32'(bit_of(10)));
    drive(4'b0111);
    chk("R2 INT4 high nibble", 32'(irq), 32'(bit_of(4)));
    chk("R6 held", 32'(irq), 32'(bit_of(4)));
    drive(4'b0111);
    chk("R6 still held", 32'(irq), 32'(bit_of(4)));
    drive(4'b1111);

    // R3 sensitivity readback, upper bits dropped
    wr(8'h44, 8'hFF);
    rd("R3 upper zero", 8'h44, 8'h0F);
    wr(8'h44, 8'h02);
    rd("R3 readback", 8'h44, 8'h02);

    // R7 edge pulse on INT2 (IRQ3), INT1 stays level (IRQ9)
    drive(4'b1101);
    chk("R7 pulse", 32'(irq), 32'(bit_of(3)));
    drive(4'b1101);
    chk("R7 pulse ends", 32'(irq), 32'h0);
    drive(4'b1101);
    chk("R7 no repeat", 32'(irq), 32'h0);
    drive(4'b1100);
    chk("R3 INT1 level beside edge", 32'(irq), 32'(bit_of(9)));
    drive(4'b1111);
    chk("R6 release INT1", 32'(irq), 32'h0);
    drive(4'b1101);
    chk("R7 second pulse", 32'(irq), 32'(bit_of(3)));
    drive(4'b1111);
    chk("R7 second pulse ends", 32'(irq), 32'h0);

    // R8 sharing: INT1 and INT3 both on IRQ5
    wr(8'h44, 8'h00);
    wr(8'h42, 8'h05);
    wr(8'h43, 8'h05);
    drive(4'b1110);
    chk("R8 INT1 alone", 32'(irq), 32'(bit_of(5)));
    drive(4'b1010);
    chk("R8 both", 32'(irq), 32'(bit_of(5)));
    drive(4'b1011);
    chk("R8 INT3 keeps", 32'(irq), 32'(bit_of(5)));
    drive(4'b1111);
    chk("R8 none", 32'(irq), 32'h0);

    // R9 foreign indices
    wr(8'h41, 8'hFF);
    wr(8'h45, 8'hFF);
    wr(8'h03, 8'hC5);
    rd("R9 map0 kept", 8'h42, 8'h05);
    rd("R9 map1 kept", 8'h43, 8'h05);
    rd("R9 sens kept", 8'h44, 8'h00);
    rd("R9 foreign read", 8'h45, 8'h00);
    drive(4'b1110);
    chk("R9 routing kept", 32'(irq), 32'(bit_of(5)));
    drive(4'b1111);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule